// File: doc/BRIEF.md
# Dual-Channel Switch-Selected Baud Clock Generator

This block produces the 16x oversampling clock enables for two independent asynchronous serial channels. It runs from a single 1.8432 MHz reference, which is the block's own clock. A shared bank of ten free-running dividers provides one enable tap for each supported line rate: 75, 110, 150, 300, 600, 1200, 1800, 2400, 4800 and 9600 baud.

Each channel has a ten-bit one-hot selection vector that models a bank of rate switches. The block routes the chosen tap to that channel's enable output. A channel whose vector has no bit set, or more than one bit set, has an invalid setting. Its enable stays low and its fault flag is raised. The two channels share the divider chain but choose their taps without affecting each other. The selection inputs are treated as quasi-static switch settings.

Top module: `dual_baud_gen`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, every divider counter is cleared and both tick outputs are low.
- R2: After `rst` is released, the first pulse of a selected tap appears on the tick output after exactly N rising edges, where N is that tap's divisor.
- R3: Each tap produces a single-cycle high pulse on every N-th rising edge, with a period of exactly N clock cycles.
- R4: Selection bit k picks one rate. The (bit, baud, divisor) pairs are (0, 75, 1536), (1, 110, 1048), (2, 150, 768), (3, 300, 384), (4, 600, 192), (5, 1200, 96), (6, 1800, 64), (7, 2400, 48), (8, 4800, 24) and (9, 9600, 12).
- R5: Channel A (`sel_a`, `tick_a`, `fault_a`) and channel B (`sel_b`, `tick_b`, `fault_b`) each follow only their own selection, even when the two select different rates.
- R6: When a selection vector is all zeros, that channel's tick stays low and its fault flag is high.
- R7: When a selection vector has two or more bits set, that channel's tick stays low and its fault flag is high.
- R8: When a selection vector has exactly one bit set, that channel's fault flag is low.
- R9: With a 1.8432 MHz clock, every tap frequency is within ±0.1% of 16 times its baud rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.8432 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_a | input | 10 | Channel A one-hot rate selection |
| sel_b | input | 10 | Channel B one-hot rate selection |
| tick_a | output | 1 | Channel A 16x clock enable pulse |
| tick_b | output | 1 | Channel B 16x clock enable pulse |
| fault_a | output | 1 | Channel A invalid-selection flag |
| fault_b | output | 1 | Channel B invalid-selection flag |

## Verification
A wrong divider terminal count or a counter that is not cleared shows at the ports as a misplaced first tick, one divisor period after reset. After that, each period between ticks is wrong by the same amount. A slow tap therefore reveals a fault only after up to 1536 cycles, so every tap is watched for two full periods. A swapped tap-to-bit mapping appears as the wrong period on the very first tick. A weak validity decode shows as a fault flag that is wrong in the same cycle, or as a stray tick within one divisor period.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int unsigned NUM_TAPS = 10;
    localparam int unsigned NUM_CHAN = 2;

    typedef logic [NUM_TAPS-1:0] tap_vec_t;

    typedef struct packed {
        logic tick;
        logic fault;
    } chan_out_t;

    // divisor of the reference for tap k (slowest rate at k = 0)
    function automatic int unsigned tap_div(input int unsigned k);
        case (k)
            0:       return 1536;
            1:       return 1048;
            2:       return 768;
            3:       return 384;
            4:       return 192;
            5:       return 96;
            6:       return 64;
            7:       return 48;
            8:       return 24;
            default: return 12;
        endcase
    endfunction

    function automatic logic exactly_one(input tap_vec_t v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            n = n + int'(v[i]);
        end
        return (n == 1);
    endfunction

endpackage

// File: rtl/baud_tap_counter.sv
module baud_tap_counter #(
    parameter int unsigned DIV = 12
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    // R3: the count never leaves its range
    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R3: a pulse lasts one cycle
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R2: counting restarts from zero right after each pulse
    assert_restart_after_tick_R2: assert property (@(posedge clk) disable iff (rst)
        tick |-> (cnt == CW'(0) || cnt == CW'(1)));

endmodule

// File: rtl/baud_chan_select.sv
module baud_chan_select
    import baud_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tap_vec_t  sel,
    input  tap_vec_t  taps,
    output chan_out_t out
);
    logic valid;

    always_comb begin
        valid     = exactly_one(sel);
        out.fault = ~valid;
        out.tick  = valid & (|(sel & taps));
    end

    // R6, R7: an invalid setting never lets a pulse through
    assert_fault_blocks_tick_R7: assert property (@(posedge clk) disable iff (rst)
        out.fault |-> !out.tick);

    // R8: a one-hot setting is never flagged
    assert_onehot_no_fault_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot(sel) |-> !out.fault);

    // R6: an empty setting is always flagged
    assert_empty_flagged_R6: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |-> out.fault);

endmodule

// File: rtl/dual_baud_gen.sv
module dual_baud_gen
    import baud_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_TAPS-1:0] sel_a,
    input  logic [NUM_TAPS-1:0] sel_b,
    output logic                tick_a,
    output logic                tick_b,
    output logic                fault_a,
    output logic                fault_b
);
    tap_vec_t  taps;
    tap_vec_t  sel_arr [NUM_CHAN];
    chan_out_t ch_out  [NUM_CHAN];

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        baud_tap_counter #(
            .DIV (tap_div(t))
        ) u_cnt (
            .clk  (clk),
            .rst  (rst),
            .tick (taps[t])
        );
    end

    assign sel_arr[0] = sel_a;
    assign sel_arr[1] = sel_b;

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        baud_chan_select u_sel (
            .clk  (clk),
            .rst  (rst),
            .sel  (sel_arr[c]),
            .taps (taps),
            .out  (ch_out[c])
        );
    end

    assign tick_a  = ch_out[0].tick;
    assign fault_a = ch_out[0].fault;
    assign tick_b  = ch_out[1].tick;
    assign fault_b = ch_out[1].fault;

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: the cycle after a sampled reset has no pulse on either channel
    always_ff @(posedge clk) begin
        if (rst_q) begin
            assert_reset_quiet_R1: assert (!tick_a && !tick_b);
        end
    end

endmodule

// File: tb/dual_baud_gen_tb_top.sv
module dual_baud_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] sel_a = 10'b0000000001;
    logic [9:0] sel_b = 10'b1000000000;
    logic       tick_a, tick_b, fault_a, fault_b;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_baud_gen dut_i (
        .clk     (clk),
        .rst     (rst),
        .sel_a   (sel_a),
        .sel_b   (sel_b),
        .tick_a  (tick_a),
        .tick_b  (tick_b),
        .fault_a (fault_a),
        .fault_b (fault_b)
    );

    function automatic int exp_div(input int k);
        int d [10] = '{1536, 1048, 768, 384, 192, 96, 64, 48, 24, 12};
        return d[k];
    endfunction

    function automatic int exp_baud(input int k);
        int b [10] = '{75, 110, 150, 300, 600, 1200, 1800, 2400, 4800, 9600};
        return b[k];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet while reset is held
        check(!tick_a && !tick_b, "R1 ticks low in reset", int'({tick_a, tick_b}), 0);
        rst = 1'b0;
    endtask

    // div = 0 means the channel must stay silent and flag a fault
    task automatic run_pass(input logic [9:0] sa, input logic [9:0] sb,
                            input int div_a, input int div_b, input int ncyc);
        int bad_a = 0, bad_b = 0, first_a = 0, second_a = 0, first_b = 0;
        int fa_bad = 0, fb_bad = 0;
        @(negedge clk);
        sel_a = sa;
        sel_b = sb;
        do_reset();
        for (int n = 1; n <= ncyc; n++) begin
            bit ea, eb;
            @(posedge clk);
            @(negedge clk);
            ea = (div_a != 0) && (n % div_a == 0);
            eb = (div_b != 0) && (n % div_b == 0);
            if (tick_a !== ea) bad_a++;
            if (tick_b !== eb) bad_b++;
            if (fault_a !== (div_a == 0)) fa_bad++;
            if (fault_b !== (div_b == 0)) fb_bad++;
            if (tick_a === 1'b1) begin
                if (first_a == 0) first_a = n;
                else if (second_a == 0) second_a = n;
            end
            if (tick_b === 1'b1 && first_b == 0) first_b = n;
        end
        // R3, R4, R5: every cycle matches the divisor of the chosen bit
        check(bad_a == 0, "R3 R4 R5 channel A tick pattern", bad_a, 0);
        check(bad_b == 0, "R3 R4 R5 channel B tick pattern", bad_b, 0);
        if (div_a != 0) begin
            // R2: first pulse after exactly one period
            check(first_a == div_a, "R2 channel A first tick", first_a, div_a);
            check(first_b == div_b, "R2 channel B first tick", first_b, div_b);
            check(fa_bad == 0 && fb_bad == 0, "R8 fault low for one-hot", fa_bad + fb_bad, 0);
        end else begin
            // R6 / R7: silent channel with the fault flag raised
            check(first_a == 0 && first_b == 0, "R6 R7 no tick when invalid", first_a + first_b, 0);
            check(fa_bad == 0 && fb_bad == 0, "R6 R7 fault high when invalid", fa_bad + fb_bad, 0);
        end
        if (div_a != 0) begin
            longint p, lhs, tol;
            int k;
            k = 0;
            for (int i = 0; i < 10; i++) if (sa[i]) k = i;
            p   = second_a - first_a;
            lhs = 64'd1843200 * 1000 - longint'(16 * exp_baud(k)) * p * 1000;
            if (lhs < 0) lhs = -lhs;
            tol = longint'(16 * exp_baud(k)) * p;
            // R9: measured period gives a rate within 0.1 percent
            check(p > 0 && lhs <= tol, "R9 rate accuracy", int'(p), exp_div(k));
        end
    endtask

    initial begin
        for (int k = 0; k < 10; k++) begin
            run_pass(10'(1 << k), 10'(1 << (9 - k)), exp_div(k), exp_div(9 - k),
                     2 * ((exp_div(k) > exp_div(9 - k)) ? exp_div(k) : exp_div(9 - k)) + 5);
        end
        // R6: zero-hot on both channels
        run_pass(10'b0, 10'b0, 0, 0, 1600);
        // R7: multi-hot on both channels
        run_pass(10'b1000000001, 10'b1111111111, 0, 0, 1600);
        run_pass(10'b0000110000, 10'b0000000011, 0, 0, 1600);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(64'd200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule